// File: doc/BRIEF.md
# Outstanding Miss Request Tracker

This block sits between a processor port and a cache controller and records every memory request still waiting for the cache. Each request carries a kind (load, instruction fetch, store, the two halves of a plain or locked read-modify-write, load-linked, store-conditional), an access mode, a byte address and a length. The block clears the offset bits of the address to get the line address. It then answers in the same cycle with one of three results: the request was issued, it aliases a line that already has a request pending, or the tracker is full. An issued request is placed in one of two small content-addressed tables. Read-class kinds go to the read table and all others go to the write table. On the next clock the request appears on the issue port with a coherence class and a normalised access mode.

Completions arrive on two separate callback ports, one for reads and one for writes. Each completion frees the matching entry and reports the request's age in cycles as its miss latency. Four counters record which kind of request stalled behind which kind of pending entry. A scanning watchdog raises a sticky deadlock flag once any entry has waited too long. A completion that matches nothing raises a sticky error flag.

Top module: `miss_tracker`

## Requirements
- R1: Kinds 0 (load) and 1 (instruction fetch) are held in the read table. Kinds 2 to 8 (store 2, read-modify-write read 3, read-modify-write write 4, locked read 5, locked write 6, load-linked 7, store-conditional 8) are held in the write table. A line may not be entered twice.
- R2: `req_status` is 2 (aliased) when the request's line is in the write table. In that case `st_wait_ld` increments when the kind is 0, 1 or 3, and `st_wait_st` increments for any other kind.
- R3: Otherwise, `req_status` is 2 when the line is in the read table. In that case `ld_wait_st` increments when the kind is 2 or 4, and `ld_wait_ld` increments for any other kind.
- R4: When there is no alias and `outstanding` is at or above `MAX_OUT`, or the target table has no free slot, `req_status` is 3 (full) and nothing is recorded. Otherwise it is 1 (issued). It is 0 when `req_valid` is low.
- R5: `outstanding` is 0 after reset. It rises by one per issued request and falls by one per matched completion, and it always equals the total occupancy of the two tables.
- R6: The cycle after an issue, `iss_valid` pulses high. `iss_class` is 0 for instruction fetch, 1 for load, 2 for store and every plain or locked read-modify-write kind, and 3 for load-linked and store-conditional.
- R7: `iss_mode` carries mode 0 (user) and 1 (supervisor) unchanged, and turns mode 2 (device) into 0.
- R8: `deadlock` is 0 after reset. It becomes 1 once some entry has an age of at least `DL_THRESH` cycles, and it stays 1 until reset.
- R9: A completion that matches an entry frees it. The next cycle, the port's latency valid pulses and the latency value equals the number of cycles from the issue cycle to the completion cycle. The pulse is only given for a non-zero latency.
- R10: A completion whose line is in neither table sets the sticky `orphan_err` and leaves `outstanding` unchanged.
- R11: The low log2(`LINE_BYTES`) address bits are ignored. Requests, callbacks and `iss_line` all use the line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present |
| req_kind | input | 4 | Request kind code |
| req_mode | input | 2 | Access mode: 0 user, 1 supervisor, 2 device |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | log2(LINE_BYTES)+1 | Access length in bytes |
| req_status | output | 2 | 0 none, 1 issued, 2 aliased, 3 full |
| iss_valid | output | 1 | Issue port valid |
| iss_class | output | 2 | Coherence class of the issued request |
| iss_mode | output | 2 | Normalised access mode |
| iss_line | output | ADDR_W | Issued line address |
| rd_cb_valid | input | 1 | Read completion |
| rd_cb_addr | input | ADDR_W | Read completion address |
| wr_cb_valid | input | 1 | Write completion |
| wr_cb_addr | input | ADDR_W | Write completion address |
| rd_lat_valid | output | 1 | Read latency report |
| rd_lat | output | TIME_W | Read miss latency in cycles |
| wr_lat_valid | output | 1 | Write latency report |
| wr_lat | output | TIME_W | Write miss latency in cycles |
| outstanding | output | log2(RD_ENTRIES+WR_ENTRIES+1) | Pending request count |
| st_wait_ld | output | CNT_W | Read-type request stalled on a write-table entry |
| st_wait_st | output | CNT_W | Write-type request stalled on a write-table entry |
| ld_wait_st | output | CNT_W | Store-type request stalled on a read-table entry |
| ld_wait_ld | output | CNT_W | Other request stalled on a read-table entry |
| deadlock | output | 1 | Sticky age watchdog flag |
| orphan_err | output | 1 | Sticky unmatched completion flag |

## Verification
The assertions assume several things about the inputs. A request never runs past the end of its line, and `req_kind` stays within 0 to 8. The controller only completes lines that the tracker issued, except when an orphan is deliberately injected. The stimulus keeps every offset plus length inside 64 bytes and uses only the nine defined kinds. It sends each completion once, to the table that owns the line. It drives the single unmatched completion only after every matched one has been checked. The deadlock case runs after a fresh reset, so the sticky flag from that test cannot hide other results.

// File: rtl/miss_tracker_pkg.sv
package miss_tracker_pkg;

  localparam logic [3:0] K_LOAD    = 4'd0;
  localparam logic [3:0] K_IFETCH  = 4'd1;
  localparam logic [3:0] K_STORE   = 4'd2;
  localparam logic [3:0] K_RMW_RD  = 4'd3;
  localparam logic [3:0] K_RMW_WR  = 4'd4;
  localparam logic [3:0] K_LRMW_RD = 4'd5;
  localparam logic [3:0] K_LRMW_WR = 4'd6;
  localparam logic [3:0] K_LINKED  = 4'd7;
  localparam logic [3:0] K_COND    = 4'd8;

  localparam logic [1:0] C_IFETCH = 2'd0;
  localparam logic [1:0] C_LD     = 2'd1;
  localparam logic [1:0] C_ST     = 2'd2;
  localparam logic [1:0] C_ATOMIC = 2'd3;

  localparam logic [1:0] M_USER   = 2'd0;
  localparam logic [1:0] M_SUPER  = 2'd1;
  localparam logic [1:0] M_DEVICE = 2'd2;

  localparam logic [1:0] S_NONE   = 2'd0;
  localparam logic [1:0] S_ISSUED = 2'd1;
  localparam logic [1:0] S_ALIAS  = 2'd2;
  localparam logic [1:0] S_FULL   = 2'd3;

  // Kinds that own the write table
  function automatic logic uses_wr_table(input logic [3:0] k);
    return !(k == K_LOAD || k == K_IFETCH);
  endfunction

  function automatic logic [1:0] coh_class(input logic [3:0] k);
    logic [1:0] c;
    case (k)
      K_IFETCH:                  c = C_IFETCH;
      K_LOAD:                    c = C_LD;
      K_LINKED, K_COND:          c = C_ATOMIC;
      default:                   c = C_ST;
    endcase
    return c;
  endfunction

  function automatic logic [1:0] norm_mode(input logic [1:0] m);
    return (m == M_DEVICE) ? M_USER : m;
  endfunction

  // Stall class against a pending write-table entry
  function automatic logic read_like(input logic [3:0] k);
    return (k == K_LOAD || k == K_IFETCH || k == K_RMW_RD);
  endfunction

  // Stall class against a pending read-table entry
  function automatic logic store_like(input logic [3:0] k);
    return (k == K_STORE || k == K_RMW_WR);
  endfunction

endpackage

// File: rtl/tracker_cam.sv
module tracker_cam #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 32,
  parameter int TIME_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  output logic              has_room,
  input  logic              ins_en,
  input  logic [TIME_W-1:0] ins_time,
  input  logic              fre_en,
  input  logic [LINE_W-1:0] fre_line,
  output logic              fre_hit,
  output logic [TIME_W-1:0] fre_time,
  input  logic [IDX_W-1:0]  scan_idx,
  output logic              scan_vld,
  output logic [TIME_W-1:0] scan_time,
  output logic [OCC_W-1:0]  occupancy
);

  logic [DEPTH-1:0]  vld_q;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [TIME_W-1:0] time_q [DEPTH];
  logic [DEPTH-1:0]  look_m, fre_m, slot_sel;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_match
      assign look_m[g] = vld_q[g] && (line_q[g] == look_line);
      assign fre_m[g]  = vld_q[g] && (line_q[g] == fre_line);
    end
  endgenerate

  assign look_hit = |look_m;
  assign fre_hit  = fre_en && (|fre_m);
  assign has_room = !(&vld_q);
  assign occupancy = OCC_W'($countones(vld_q));

  // Lowest free slot
  always_comb begin
    slot_sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) slot_sel = DEPTH'(1) << i;
    end
  end

  always_comb begin
    fre_time = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (fre_m[i]) fre_time = fre_time | time_q[i];
    end
  end

  always_comb begin
    scan_vld  = 1'b0;
    scan_time = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (scan_idx == IDX_W'(i)) begin
        scan_vld  = vld_q[i];
        scan_time = time_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fre_en && fre_m[i]) begin
          vld_q[i] <= 1'b0;
        end else if (ins_en && slot_sel[i]) begin
          vld_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ins_en && slot_sel[i]) begin
        line_q[i] <= look_line;
        time_q[i] <= ins_time;
      end
    end
  end

  AST_NO_DUP_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (!look_hit && has_room)); // R1

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_m)); // R1

endmodule

// File: rtl/age_watchdog.sv
module age_watchdog #(
  parameter int RD_N      = 4,
  parameter int WR_N      = 4,
  parameter int TIME_W    = 16,
  parameter int DL_THRESH = 200,
  localparam int TOT   = RD_N + WR_N,
  localparam int PTR_W = $clog2(TOT),
  localparam int RI_W  = (RD_N > 1) ? $clog2(RD_N) : 1,
  localparam int WI_W  = (WR_N > 1) ? $clog2(WR_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  output logic [RI_W-1:0]   rd_idx,
  output logic [WI_W-1:0]   wr_idx,
  input  logic              rd_vld,
  input  logic [TIME_W-1:0] rd_time,
  input  logic              wr_vld,
  input  logic [TIME_W-1:0] wr_time,
  output logic              deadlock
);

  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  wr_off;
  logic              in_rd;
  logic              sel_vld;
  logic [TIME_W-1:0] sel_time;
  logic              too_old;

  function automatic logic [TIME_W-1:0] age_of(input logic [TIME_W-1:0] t_now,
                                               input logic [TIME_W-1:0] t_iss);
    return t_now - t_iss;
  endfunction

  assign in_rd    = (ptr_q < PTR_W'(RD_N));
  assign wr_off   = ptr_q - PTR_W'(RD_N);
  assign rd_idx   = RI_W'(ptr_q);
  assign wr_idx   = WI_W'(wr_off);
  assign sel_vld  = in_rd ? rd_vld : wr_vld;
  assign sel_time = in_rd ? rd_time : wr_time;
  assign too_old  = sel_vld && (age_of(now, sel_time) >= TIME_W'(DL_THRESH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      deadlock <= 1'b0;
    end else begin
      ptr_q <= (ptr_q == PTR_W'(TOT - 1)) ? '0 : ptr_q + 1'b1;
      if (too_old) deadlock <= 1'b1;
    end
  end

  AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock); // R8

  AST_DEADLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> $past(too_old)); // R8

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import miss_tracker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int RD_ENTRIES = 4,
  parameter int WR_ENTRIES = 4,
  parameter int MAX_OUT    = 6,
  parameter int TIME_W     = 16,
  parameter int CNT_W      = 16,
  parameter int DL_THRESH  = 200
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         req_valid,
  input  logic [3:0]                                   req_kind,
  input  logic [1:0]                                   req_mode,
  input  logic [ADDR_W-1:0]                            req_addr,
  input  logic [$clog2(LINE_BYTES):0]                  req_len,
  output logic [1:0]                                   req_status,
  output logic                                         iss_valid,
  output logic [1:0]                                   iss_class,
  output logic [1:0]                                   iss_mode,
  output logic [ADDR_W-1:0]                            iss_line,
  input  logic                                         rd_cb_valid,
  input  logic [ADDR_W-1:0]                            rd_cb_addr,
  input  logic                                         wr_cb_valid,
  input  logic [ADDR_W-1:0]                            wr_cb_addr,
  output logic                                         rd_lat_valid,
  output logic [TIME_W-1:0]                            rd_lat,
  output logic                                         wr_lat_valid,
  output logic [TIME_W-1:0]                            wr_lat,
  output logic [$clog2(RD_ENTRIES+WR_ENTRIES+1)-1:0]   outstanding,
  output logic [CNT_W-1:0]                             st_wait_ld,
  output logic [CNT_W-1:0]                             st_wait_st,
  output logic [CNT_W-1:0]                             ld_wait_st,
  output logic [CNT_W-1:0]                             ld_wait_ld,
  output logic                                         deadlock,
  output logic                                         orphan_err
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int OUT_W  = $clog2(RD_ENTRIES + WR_ENTRIES + 1);
  localparam int RI_W   = (RD_ENTRIES > 1) ? $clog2(RD_ENTRIES) : 1;
  localparam int WI_W   = (WR_ENTRIES > 1) ? $clog2(WR_ENTRIES) : 1;
  localparam int RO_W   = $clog2(RD_ENTRIES + 1);
  localparam int WO_W   = $clog2(WR_ENTRIES + 1);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a & ~OFF_MASK;
  endfunction

  function automatic logic [TIME_W-1:0] span(input logic [TIME_W-1:0] t_now,
                                             input logic [TIME_W-1:0] t_iss);
    return t_now - t_iss;
  endfunction

  // Free-running time base
  logic [TIME_W-1:0] now_q;
  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  logic [ADDR_W-1:0] req_line, rd_cb_line, wr_cb_line;
  assign req_line   = line_of(req_addr);
  assign rd_cb_line = line_of(rd_cb_addr);
  assign wr_cb_line = line_of(wr_cb_addr);

  logic              to_wr;
  logic              rd_hit, wr_hit, rd_room, wr_room;
  logic              rd_ins, wr_ins, accept;
  logic              rd_fre_hit, wr_fre_hit;
  logic [TIME_W-1:0] rd_fre_time, wr_fre_time;
  logic [RI_W-1:0]   rd_scan_idx;
  logic [WI_W-1:0]   wr_scan_idx;
  logic              rd_scan_vld, wr_scan_vld;
  logic [TIME_W-1:0] rd_scan_time, wr_scan_time;
  logic [RO_W-1:0]   rd_occ;
  logic [WO_W-1:0]   wr_occ;
  logic              alias_wr_ev, alias_rd_ev, full_ev;

  assign to_wr = uses_wr_table(req_kind);

  // Status decision: write-table alias has priority over read-table alias
  always_comb begin
    alias_wr_ev = 1'b0;
    alias_rd_ev = 1'b0;
    full_ev     = 1'b0;
    req_status  = S_NONE;
    if (req_valid) begin
      if (wr_hit) begin
        alias_wr_ev = 1'b1;
        req_status  = S_ALIAS;
      end else if (rd_hit) begin
        alias_rd_ev = 1'b1;
        req_status  = S_ALIAS;
      end else if (outstanding >= OUT_W'(MAX_OUT) || !(to_wr ? wr_room : rd_room)) begin
        full_ev    = 1'b1;
        req_status = S_FULL;
      end else begin
        req_status = S_ISSUED;
      end
    end
  end

  assign accept = (req_status == S_ISSUED);
  assign rd_ins = accept && !to_wr;
  assign wr_ins = accept && to_wr;

  tracker_cam #(.DEPTH(RD_ENTRIES), .LINE_W(ADDR_W), .TIME_W(TIME_W)) rd_tab_i (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(rd_hit), .has_room(rd_room),
    .ins_en(rd_ins), .ins_time(now_q),
    .fre_en(rd_cb_valid), .fre_line(rd_cb_line),
    .fre_hit(rd_fre_hit), .fre_time(rd_fre_time),
    .scan_idx(rd_scan_idx), .scan_vld(rd_scan_vld), .scan_time(rd_scan_time),
    .occupancy(rd_occ)
  );

  tracker_cam #(.DEPTH(WR_ENTRIES), .LINE_W(ADDR_W), .TIME_W(TIME_W)) wr_tab_i (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(wr_hit), .has_room(wr_room),
    .ins_en(wr_ins), .ins_time(now_q),
    .fre_en(wr_cb_valid), .fre_line(wr_cb_line),
    .fre_hit(wr_fre_hit), .fre_time(wr_fre_time),
    .scan_idx(wr_scan_idx), .scan_vld(wr_scan_vld), .scan_time(wr_scan_time),
    .occupancy(wr_occ)
  );

  age_watchdog #(.RD_N(RD_ENTRIES), .WR_N(WR_ENTRIES), .TIME_W(TIME_W),
                 .DL_THRESH(DL_THRESH)) wdog_i (
    .clk(clk), .rst_n(rst_n), .now(now_q),
    .rd_idx(rd_scan_idx), .wr_idx(wr_scan_idx),
    .rd_vld(rd_scan_vld), .rd_time(rd_scan_time),
    .wr_vld(wr_scan_vld), .wr_time(wr_scan_time),
    .deadlock(deadlock)
  );

  // Outstanding count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
    end else begin
      outstanding <= outstanding + OUT_W'(accept) - OUT_W'(rd_fre_hit) - OUT_W'(wr_fre_hit);
    end
  end

  // Stall-class counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_wait_ld <= '0;
      st_wait_st <= '0;
      ld_wait_st <= '0;
      ld_wait_ld <= '0;
    end else begin
      if (alias_wr_ev &&  read_like(req_kind))  st_wait_ld <= st_wait_ld + 1'b1;
      if (alias_wr_ev && !read_like(req_kind))  st_wait_st <= st_wait_st + 1'b1;
      if (alias_rd_ev &&  store_like(req_kind)) ld_wait_st <= ld_wait_st + 1'b1;
      if (alias_rd_ev && !store_like(req_kind)) ld_wait_ld <= ld_wait_ld + 1'b1;
    end
  end

  // Issue port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_class <= C_IFETCH;
      iss_mode  <= M_USER;
      iss_line  <= '0;
    end else begin
      iss_valid <= accept;
      if (accept) begin
        iss_class <= coh_class(req_kind);
        iss_mode  <= norm_mode(req_mode);
        iss_line  <= req_line;
      end
    end
  end

  // Completion reporting
  logic [TIME_W-1:0] rd_span, wr_span;
  assign rd_span = span(now_q, rd_fre_time);
  assign wr_span = span(now_q, wr_fre_time);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_lat_valid <= 1'b0;
      wr_lat_valid <= 1'b0;
      rd_lat       <= '0;
      wr_lat       <= '0;
      orphan_err   <= 1'b0;
    end else begin
      rd_lat_valid <= rd_fre_hit && (rd_span != '0);
      wr_lat_valid <= wr_fre_hit && (wr_span != '0);
      if (rd_fre_hit) rd_lat <= rd_span;
      if (wr_fre_hit) wr_lat <= wr_span;
      if ((rd_cb_valid && !rd_fre_hit) || (wr_cb_valid && !wr_fre_hit)) orphan_err <= 1'b1;
    end
  end

  AST_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, req_addr[OFF_W-1:0]} + req_len) <= (OFF_W+1)'(LINE_BYTES)); // R11

  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding == (OUT_W'(rd_occ) + OUT_W'(wr_occ))); // R5

  AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (outstanding < OUT_W'(MAX_OUT))); // R4

  AST_ISSUE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> iss_valid); // R6

  AST_ISSUE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> $past(accept)); // R6

  AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lat_valid |-> (rd_lat != '0)); // R9

  AST_ORPHAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_err |=> orphan_err); // R10

  AST_ALIAS_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_status == S_ALIAS) |=> $stable(outstanding) || $past(rd_fre_hit || wr_fre_hit)); // R2

endmodule

// File: tb/miss_tracker_tb.sv
module miss_tracker_tb_top;

  localparam int AW  = 32;
  localparam int THR = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [3:0]    req_kind = '0;
  logic [1:0]    req_mode = '0;
  logic [AW-1:0] req_addr = '0;
  logic [6:0]    req_len = 7'd4;
  logic [1:0]    req_status;
  logic          iss_valid;
  logic [1:0]    iss_class, iss_mode;
  logic [AW-1:0] iss_line;
  logic          rd_cb_valid = 1'b0, wr_cb_valid = 1'b0;
  logic [AW-1:0] rd_cb_addr = '0, wr_cb_addr = '0;
  logic          rd_lat_valid, wr_lat_valid;
  logic [15:0]   rd_lat, wr_lat;
  logic [3:0]    outstanding;
  logic [15:0]   st_wait_ld, st_wait_st, ld_wait_st, ld_wait_ld;
  logic          deadlock, orphan_err;

  miss_tracker #(.DL_THRESH(THR)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_mode(req_mode), .req_addr(req_addr), .req_len(req_len),
    .req_status(req_status), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_mode(iss_mode), .iss_line(iss_line),
    .rd_cb_valid(rd_cb_valid), .rd_cb_addr(rd_cb_addr),
    .wr_cb_valid(wr_cb_valid), .wr_cb_addr(wr_cb_addr),
    .rd_lat_valid(rd_lat_valid), .rd_lat(rd_lat),
    .wr_lat_valid(wr_lat_valid), .wr_lat(wr_lat),
    .outstanding(outstanding),
    .st_wait_ld(st_wait_ld), .st_wait_st(st_wait_st),
    .ld_wait_st(ld_wait_st), .ld_wait_ld(ld_wait_ld),
    .deadlock(deadlock), .orphan_err(orphan_err)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind, mode, addr, expected status, expected class, expected mode
  typedef struct packed {
    logic [3:0]  kind;
    logic [1:0]  mode;
    logic [31:0] addr;
    logic [1:0]  st;
    logic [1:0]  cls;
    logic [1:0]  md;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 2'd0, 32'h1000, 2'd1, 2'd1, 2'd0},   // load -> LD (R6)
    '{4'd1, 2'd2, 32'h2000, 2'd1, 2'd0, 2'd0},   // ifetch, device->user (R7)
    '{4'd2, 2'd1, 32'h3004, 2'd1, 2'd2, 2'd1},   // store, supervisor (R7)
    '{4'd7, 2'd0, 32'h4000, 2'd1, 2'd3, 2'd0},   // load-linked -> ATOMIC
    '{4'd0, 2'd0, 32'h3010, 2'd2, 2'd0, 2'd0},   // alias on write table (R2)
    '{4'd8, 2'd0, 32'h4020, 2'd2, 2'd0, 2'd0},   // SC alias on write table (R2)
    '{4'd2, 2'd0, 32'h1008, 2'd2, 2'd0, 2'd0},   // store alias on read table (R3)
    '{4'd1, 2'd0, 32'h2030, 2'd2, 2'd0, 2'd0},   // ifetch alias on read table (R3)
    '{4'd3, 2'd0, 32'h5000, 2'd1, 2'd2, 2'd0},   // rmw read -> ST
    '{4'd6, 2'd0, 32'h6000, 2'd1, 2'd2, 2'd0},   // locked rmw write -> ST
    '{4'd0, 2'd0, 32'h7000, 2'd3, 2'd0, 2'd0},   // full at MAX_OUT (R4)
    '{4'd3, 2'd0, 32'h3000, 2'd2, 2'd0, 2'd0}    // rmw read alias on write table (R2)
  };

  int iss_cyc [NV];

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; rd_cb_valid = 1'b0; wr_cb_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [3:0] k, input logic [1:0] m, input logic [31:0] a);
    req_valid = 1'b1; req_kind = k; req_mode = m; req_addr = a; req_len = 7'd4;
  endtask

  initial begin : wdog
    #300000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c0, t0;
    logic prev_iss;
    vec_t pv;
    do_reset();
    @(negedge clk);
    chk(outstanding == 0, "R5 reset count", outstanding, 0);
    chk(deadlock == 0, "R8 reset deadlock", deadlock, 0);
    chk(orphan_err == 0, "R10 reset orphan", orphan_err, 0);
    chk(iss_valid == 0, "R6 reset issue", iss_valid, 0);
    chk(req_status == 0, "R4 idle status", req_status, 0);

    prev_iss = 1'b0;
    pv = '0;
    for (int i = 0; i < NV; i++) begin
      if (i > 0) begin
        @(negedge clk);
        chk(iss_valid == prev_iss, "R6 issue pulse", iss_valid, prev_iss);
        if (prev_iss) begin
          chk(iss_class == pv.cls, "R6 class", iss_class, pv.cls);
          chk(iss_mode == pv.md, "R7 mode", iss_mode, pv.md);
          chk(iss_line == (pv.addr & ~32'h3f), "R11 line", iss_line, pv.addr & ~32'h3f);
        end
      end
      send(VEC[i].kind, VEC[i].mode, VEC[i].addr);
      #1;
      chk(req_status == VEC[i].st, "R1 R4 status", req_status, VEC[i].st);
      iss_cyc[i] = cyc;
      prev_iss = (VEC[i].st == 2'd1);
      pv = VEC[i];
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(iss_valid == 1'b0, "R6 no issue after alias", iss_valid, 0);
    chk(st_wait_ld == 2, "R2 st_wait_ld", st_wait_ld, 2);
    chk(st_wait_st == 1, "R2 st_wait_st", st_wait_st, 1);
    chk(ld_wait_st == 1, "R3 ld_wait_st", ld_wait_st, 1);
    chk(ld_wait_ld == 1, "R3 ld_wait_ld", ld_wait_ld, 1);
    chk(outstanding == 6, "R5 count six", outstanding, 6);

    // read completion with offset bits set
    repeat (3) @(negedge clk);
    rd_cb_valid = 1'b1; rd_cb_addr = 32'h1024; c0 = cyc;
    @(negedge clk);
    rd_cb_valid = 1'b0;
    chk(rd_lat_valid == 1'b1, "R9 rd latency valid", rd_lat_valid, 1);
    chk(rd_lat == 16'(c0 - iss_cyc[0]), "R9 rd latency", rd_lat, c0 - iss_cyc[0]);
    chk(outstanding == 5, "R5 after free", outstanding, 5);
    chk(orphan_err == 0, "R10 matched no error", orphan_err, 0);

    // room again
    send(4'd0, 2'd0, 32'h7008);
    #1;
    chk(req_status == 2'd1, "R4 issue after free", req_status, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(iss_line == 32'h7000, "R11 issued line", iss_line, 32'h7000);
    chk(iss_class == 2'd1, "R6 class load", iss_class, 1);

    // write completion of the store line
    wr_cb_valid = 1'b1; wr_cb_addr = 32'h3000; c0 = cyc;
    @(negedge clk);
    wr_cb_valid = 1'b0;
    chk(wr_lat_valid == 1'b1, "R9 wr latency valid", wr_lat_valid, 1);
    chk(wr_lat == 16'(c0 - iss_cyc[2]), "R9 wr latency", wr_lat, c0 - iss_cyc[2]);
    chk(outstanding == 5, "R5 after write free", outstanding, 5);

    send(4'd2, 2'd0, 32'h3000);
    #1;
    chk(req_status == 2'd1, "R1 line reusable", req_status, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(outstanding == 6, "R5 count back to six", outstanding, 6);

    // unmatched completion
    wr_cb_valid = 1'b1; wr_cb_addr = 32'h9000;
    @(negedge clk);
    wr_cb_valid = 1'b0;
    chk(orphan_err == 1'b1, "R10 orphan flag", orphan_err, 1);
    chk(wr_lat_valid == 1'b0, "R10 no latency", wr_lat_valid, 0);
    chk(outstanding == 6, "R10 count unchanged", outstanding, 6);
    @(negedge clk);
    chk(orphan_err == 1'b1, "R10 orphan sticky", orphan_err, 1);

    // deadlock watchdog
    do_reset();
    @(negedge clk);
    chk(deadlock == 0, "R8 clear after reset", deadlock, 0);
    send(4'd2, 2'd0, 32'h8000);
    t0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc < t0 + THR - 1) @(negedge clk);
    chk(deadlock == 0, "R8 young entry", deadlock, 0);
    while (cyc < t0 + THR + 12) @(negedge clk);
    chk(deadlock == 1, "R8 old entry", deadlock, 1);
    wr_cb_valid = 1'b1; wr_cb_addr = 32'h8000;
    @(negedge clk);
    wr_cb_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(deadlock == 1, "R8 sticky", deadlock, 1);
    chk(outstanding == 0, "R5 empty", outstanding, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule